// File: doc/BRIEF.md
# Clause-45 MDIO Management Master

This block is a memory-mapped master for the two-wire management bus used to reach PHY registers with Clause-45 framing. Software sees four 32-bit registers: configuration/status, control, data and address. It sets a port address, a device address and a 16-bit register address. A Clause-45 access is made of separate frames, and each frame is started by its own register write. Writing the address register sends an address frame. Writing the data register sends a write frame. Writing control with its read bit set sends a read frame, which may ask the PHY to post-increment its address.

The block divides the system clock to make the management clock. It drives the data line on falling clock edges and samples it on rising edges. During a read it releases the line from the first turnaround bit until the frame ends. Two busy flags report progress: one in status covers address frames, and one in the data register covers write and read frames. A read that gets no answer from the PHY sets an error flag.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads as zero, the clock output is low and the data line is not driven.
- R2: Register words sit at byte offsets 0x30 (status), 0x34 (control), 0x38 (data) and 0x3C (address). Status bits 15:8 hold the divider field and read back. Control bits 4:0 hold the device address, bits 9:5 the port address, bit 10 preamble disable and bit 14 post-increment, and all of them read back. Control bit 15 always reads as 0.
- R3: While a frame runs, each half-period of the management clock lasts max(divider field, 1) system clocks. While no frame runs the clock is low.
- R4: A write to the address register while idle stores bits 15:0 and sends, MSB first, 32 ones, start 00, opcode 00, the port address, the device address, turnaround 10 and the address. Status bit 0 stays 1 until the frame ends.
- R5: A write to the data register while idle stores bits 15:0 and sends the same frame layout with opcode 01 and the data as payload. Data bit 31 goes to 1 at the write edge and clears exactly 2*H*N system clocks later, where H is the half-period and N is the frame length in bits.
- R6: A control write with bit 15 set, made while idle, sends a read frame. Its opcode is 11, or 10 when bit 14 is set. The port and device come from that same write. The master drives the line only up to the last bit before turnaround. When data bit 31 clears, data bits 15:0 hold the 16 bits the PHY returned.
- R7: If the line is not low during the second turnaround bit of a read, status bit 1 is set. The next read start clears it.
- R8: With control bit 10 set, the 32-bit preamble is left out and the frame is 32 bits long.
- R9: While either busy flag is set, writes to the address or data register, and control writes with bit 15 set, are ignored: no register changes and no frame is sent.
- R10: The master's data line and its enable change only while the management clock is low, so they are stable for the whole high phase.
- R11: Control bit 11 is stored and reads back, but it does not change any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte address of the register word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe_o | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
A register write is taken at one clock edge. Stored fields and the busy flags can be read just after that edge, because read data is combinational. The management clock first rises H clocks after the start edge, and the frame ends with the falling edge 2*H*N clocks after the start. The bench checks this bound for a 64-bit write frame with H=2: data bit 31 must still be 1 at clock 255 and must be 0 at clock 256. The other frame checks wait for the busy flags to drop and then compare the line values captured at each rising edge of the management clock against a frame built from the requirements.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic [1:0] {FR_ADDR, FR_WRITE, FR_READ} frame_kind_e;

  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  // bit index (preamble-aligned) where the read turnaround starts
  localparam int unsigned TA_IDX     = PRE_BITS + 14;

  localparam logic [3:0] W_STAT = 4'd12;
  localparam logic [3:0] W_CTL  = 4'd13;
  localparam logic [3:0] W_DATA = 4'd14;
  localparam logic [3:0] W_ADDR = 4'd15;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half;
  logic             wrap;

  assign half   = (div_i == '0) ? DIV_W'(1) : div_i;
  assign wrap   = run_i && (cnt_q == half - DIV_W'(1));
  assign rise_o = wrap && !mdc_o;
  assign fall_o = wrap && mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_o <= !mdc_o;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  frame_kind_e kind_i,
  input  logic [4:0]  port_i,
  input  logic [4:0]  dev_i,
  input  logic        pre_dis_i,
  input  logic        post_inc_i,
  input  logic [15:0] payload_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        active_o,
  output logic        done_o,
  output frame_kind_e done_kind_o,
  output logic [15:0] rd_data_o,
  output logic        rd_err_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [IDX_W-1:0]      idx_q;
  logic [15:0]           rx_q;
  logic                  err_q;
  frame_kind_e           kind_q;
  logic [1:0]            op;
  logic [31:0]           frame32;
  logic                  is_rd;

  always_comb begin
    unique case (kind_i)
      FR_ADDR:  op = 2'b00;
      FR_WRITE: op = 2'b01;
      default:  op = post_inc_i ? 2'b10 : 2'b11;
    endcase
  end

  assign frame32     = {2'b00, op, port_i, dev_i, 2'b10, payload_i};
  assign is_rd       = (kind_q == FR_READ);
  assign done_o      = active_o && fall_i && (idx_q == IDX_W'(FRAME_BITS - 1));
  assign done_kind_o = kind_q;
  assign rd_data_o   = rx_q;
  assign rd_err_o    = err_q;
  assign mdio_oe_o   = active_o && !(is_rd && (idx_q >= IDX_W'(TA_IDX)));
  assign mdio_o      = mdio_oe_o && tx_q[FRAME_BITS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      tx_q     <= '0;
      idx_q    <= '0;
      rx_q     <= '0;
      err_q    <= 1'b0;
      kind_q   <= FR_ADDR;
    end else if (start_i && !active_o) begin
      active_o <= 1'b1;
      kind_q   <= kind_i;
      err_q    <= 1'b0;
      tx_q     <= pre_dis_i ? {frame32, 32'h0} : {32'hFFFF_FFFF, frame32};
      idx_q    <= pre_dis_i ? IDX_W'(PRE_BITS) : '0;
    end else if (active_o) begin
      if (rise_i && is_rd) begin
        if (idx_q == IDX_W'(TA_IDX + 1)) err_q <= mdio_i;
        if (idx_q > IDX_W'(TA_IDX + 1))  rx_q  <= {rx_q[14:0], mdio_i};
      end
      if (fall_i) begin
        if (done_o) begin
          active_o <= 1'b0;
        end else begin
          tx_q  <= tx_q << 1;
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              done_i,
  input  frame_kind_e       done_kind_i,
  input  logic [15:0]       rd_data_i,
  input  logic              rd_err_i,
  output logic              start_o,
  output frame_kind_e       kind_o,
  output logic [4:0]        port_o,
  output logic [4:0]        dev_o,
  output logic              pre_dis_o,
  output logic              post_inc_o,
  output logic [15:0]       payload_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              addr_busy_o,
  output logic              data_busy_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [4:0]  dev_q, port_q;
  logic        pre_dis_q, scan_q, post_inc_q;
  logic [15:0] data_q, addr_q;
  logic        rd_err_q;
  logic        busy, st_addr, st_wr, st_rd, ctl_upd;

  assign word    = addr_i[ADDR_W-1:2];
  assign busy    = addr_busy_o || data_busy_o;
  assign st_addr = we_i && (word == WORD_W'(W_ADDR)) && !busy;
  assign st_wr   = we_i && (word == WORD_W'(W_DATA)) && !busy;
  assign st_rd   = we_i && (word == WORD_W'(W_CTL)) && wdata_i[15] && !busy;
  assign ctl_upd = we_i && (word == WORD_W'(W_CTL)) && !(wdata_i[15] && busy);

  assign start_o    = st_addr || st_wr || st_rd;
  assign kind_o     = st_rd ? FR_READ : (st_wr ? FR_WRITE : FR_ADDR);
  assign port_o     = st_rd ? wdata_i[9:5] : port_q;
  assign dev_o      = st_rd ? wdata_i[4:0] : dev_q;
  assign pre_dis_o  = st_rd ? wdata_i[10] : pre_dis_q;
  assign post_inc_o = wdata_i[14];
  assign payload_o  = wdata_i[15:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o       <= '0;
      dev_q       <= '0;
      port_q      <= '0;
      pre_dis_q   <= 1'b0;
      scan_q      <= 1'b0;
      post_inc_q  <= 1'b0;
      data_q      <= '0;
      addr_q      <= '0;
      rd_err_q    <= 1'b0;
      addr_busy_o <= 1'b0;
      data_busy_o <= 1'b0;
    end else begin
      if (we_i && (word == WORD_W'(W_STAT))) div_o <= wdata_i[8 +: DIV_W];
      if (ctl_upd) begin
        dev_q      <= wdata_i[4:0];
        port_q     <= wdata_i[9:5];
        pre_dis_q  <= wdata_i[10];
        scan_q     <= wdata_i[11];
        post_inc_q <= wdata_i[14];
      end
      if (st_addr) begin
        addr_q      <= wdata_i[15:0];
        addr_busy_o <= 1'b1;
      end
      if (st_wr) begin
        data_q      <= wdata_i[15:0];
        data_busy_o <= 1'b1;
      end
      if (st_rd) begin
        rd_err_q    <= 1'b0;
        data_busy_o <= 1'b1;
      end
      if (done_i) begin
        if (done_kind_i == FR_ADDR) begin
          addr_busy_o <= 1'b0;
        end else begin
          data_busy_o <= 1'b0;
        end
        if (done_kind_i == FR_READ) begin
          data_q   <= rd_data_i;
          rd_err_q <= rd_err_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (word)
      WORD_W'(W_STAT): begin
        rdata_o[8 +: DIV_W] = div_o;
        rdata_o[1]          = rd_err_q;
        rdata_o[0]          = addr_busy_o;
      end
      WORD_W'(W_CTL):  rdata_o = {16'h0, 1'b0, post_inc_q, 2'b00, scan_q,
                                  pre_dis_q, port_q, dev_q};
      WORD_W'(W_DATA): rdata_o = {data_busy_o, 15'h0, data_q};
      WORD_W'(W_ADDR): rdata_o = {16'h0, addr_q};
      default:         rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic        start, pre_dis, post_inc, done, rd_err, active, rise, fall;
  logic        addr_busy, data_busy;
  frame_kind_e kind, done_kind;
  logic [4:0]  port, dev;
  logic [15:0] payload, rd_data;
  logic [DIV_W-1:0] div;

  mdio_mgmt_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .done_i      (done),
    .done_kind_i (done_kind),
    .rd_data_i   (rd_data),
    .rd_err_i    (rd_err),
    .start_o     (start),
    .kind_o      (kind),
    .port_o      (port),
    .dev_o       (dev),
    .pre_dis_o   (pre_dis),
    .post_inc_o  (post_inc),
    .payload_o   (payload),
    .div_o       (div),
    .addr_busy_o (addr_busy),
    .data_busy_o (data_busy)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) i_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .div_i  (div),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng i_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .kind_i      (kind),
    .port_i      (port),
    .dev_i       (dev),
    .pre_dis_i   (pre_dis),
    .post_inc_i  (post_inc),
    .payload_i   (payload),
    .rise_i      (rise),
    .fall_i      (fall),
    .mdio_i      (mdio_i),
    .active_o    (active),
    .done_o      (done),
    .done_kind_o (done_kind),
    .rd_data_o   (rd_data),
    .rd_err_o    (rd_err),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mdc_i,
  input logic mdio_d_i,
  input logic mdio_oe_i,
  input logic addr_busy_i,
  input logic data_busy_i
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_busy_i || data_busy_i) |-> !mdc_i);  // R3
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_busy_i || data_busy_i) |-> !mdio_oe_i);  // R1
  AST_ONE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_busy_i && data_busy_i));  // R9
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> ($stable(mdio_d_i) && $stable(mdio_oe_i)));  // R10
  AST_DATA_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_busy_i) |-> $fell(mdc_i));  // R5
  AST_ADDR_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_busy_i) |-> $fell(mdc_i));  // R4
endmodule

bind mdio_mgmt_master mdio_mgmt_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mdc_i       (mdc_o),
  .mdio_d_i    (mdio_o),
  .mdio_oe_i   (mdio_oe_o),
  .addr_busy_i (addr_busy),
  .data_busy_i (data_busy)
);

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  localparam logic [5:0] A_STAT = 6'h30, A_CTL = 6'h34, A_DATA = 6'h38, A_ADDR = 6'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic mdc, mdio_o, mdio_oe, mdio_line;
  logic phy_en = 1'b0, phy_bit = 1'b1, phy_on = 1'b0;
  int   phy_p = 32;
  logic [15:0] phy_val = '0;
  logic [63:0] cap_v, oe_v;
  int rcnt = 0, checks = 0, fails = 0, viol = 0;
  logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

  always #2.5 clk = !clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_line)
  );

  always @(posedge mdc) begin
    if (rcnt < 64) begin
      cap_v[63-rcnt] = mdio_line;
      oe_v[63-rcnt]  = mdio_oe;
    end
    rcnt++;
  end

  always @(negedge mdc) begin
    if (phy_on && rcnt == phy_p + 15) begin
      phy_en = 1'b1; phy_bit = 1'b0;
    end else if (phy_on && rcnt >= phy_p + 16 && rcnt <= phy_p + 31) begin
      phy_en = 1'b1; phy_bit = phy_val[15-(rcnt-phy_p-16)];
    end else begin
      phy_en = 1'b0;
    end
  end

  // R10 observer: line must not move while MDC stays high
  always @(negedge clk) begin
    if (rst_n && mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) viol++;
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s, dt;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(A_STAT, s); rd(A_DATA, dt);
      if (!s[0] && !dt[31]) return;
    end
  endtask

  function automatic logic [63:0] frame(input bit pd, input logic [1:0] op, input logic [4:0] port,
                                        input logic [4:0] dev, input logic [1:0] ta, input logic [15:0] pl);
    logic [31:0] f = {2'b00, op, port, dev, ta, pl};
    return pd ? {f, 32'h0} : {32'hFFFF_FFFF, f};
  endfunction

  task automatic arm();
    cap_v = '0; oe_v = '0; rcnt = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STAT, v); chk(v == 0, "R1 stat", v, 0);
    rd(A_CTL, v);  chk(v == 0, "R1 ctl", v, 0);
    rd(A_DATA, v); chk(v == 0, "R1 data", v, 0);
    rd(A_ADDR, v); chk(v == 0, "R1 addr", v, 0);
    chk(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_STAT, 32'h0000_0300);
    rd(A_STAT, v); chk(v == 32'h0300, "R2 divider", v, 32'h0300);
    wr(A_CTL, 32'h0000_4C00 | (5'd9 << 5) | 5'd30);
    rd(A_CTL, v);
    chk(v == (32'h4C00 | (5'd9 << 5) | 5'd30), "R2 R11 control fields", v, 32'h4C00 | (5'd9 << 5) | 5'd30);
    wr(A_CTL, (5'd3 << 5) | 5'd1);
  endtask

  task automatic t_addr_frame();
    logic [31:0] v;
    int n;
    arm();
    wr(A_ADDR, 32'h0000_A5C3);
    rd(A_STAT, v); chk(v[0] == 1'b1, "R4 status busy set", v, 1);
    @(posedge mdc); @(negedge clk); n = 0;
    while (mdc) begin n++; @(negedge clk); end
    chk(n == 3, "R3 half period div=3", n, 3);
    wait_idle();
    chk(cap_v == frame(0, 2'b00, 5'd3, 5'd1, 2'b10, 16'hA5C3) && rcnt == 64, "R4 address frame",
        cap_v, frame(0, 2'b00, 5'd3, 5'd1, 2'b10, 16'hA5C3));
    rd(A_ADDR, v); chk(v == 32'hA5C3, "R4 address stored", v, 32'hA5C3);
  endtask

  task automatic t_write_frame();
    logic [31:0] v;
    wr(A_STAT, 32'h0000_0200);
    wr(A_CTL, 32'h0000_0800 | (5'd17 << 5) | 5'd4);  // scan bit set, R11
    arm();
    wr(A_DATA, 32'h0000_1E69);
    repeat (255) @(negedge clk);
    rd(A_DATA, v); chk(v[31] == 1'b1, "R5 busy at 2HN-1", v, 1);
    @(negedge clk);
    rd(A_DATA, v); chk(v == 32'h1E69, "R5 busy clear at 2HN", v, 32'h1E69);
    chk(cap_v == frame(0, 2'b01, 5'd17, 5'd4, 2'b10, 16'h1E69) && rcnt == 64, "R5 R11 write frame",
        cap_v, frame(0, 2'b01, 5'd17, 5'd4, 2'b10, 16'h1E69));
  endtask

  task automatic t_read(input bit pinc, input bit pd, input logic [15:0] val);
    logic [31:0] v;
    logic [63:0] oexp;
    int p = pd ? 0 : 32;
    wr(A_STAT, 32'h0000_0100);
    arm(); phy_on = 1'b1; phy_val = val; phy_p = p;
    wr(A_CTL, 32'h8000 | (pinc ? 32'h4000 : 0) | (pd ? 32'h0400 : 0) | (5'd22 << 5) | 5'd7);
    wait_idle();
    phy_on = 1'b0;
    oexp = '0;
    for (int k = 0; k < p + 14; k++) oexp[63-k] = 1'b1;
    chk(cap_v == frame(pd, pinc ? 2'b10 : 2'b11, 5'd22, 5'd7, 2'b10, val) && rcnt == p + 32,
        pd ? "R8 read frame no preamble" : "R6 read frame", cap_v,
        frame(pd, pinc ? 2'b10 : 2'b11, 5'd22, 5'd7, 2'b10, val));
    chk(oe_v == oexp, "R6 line release", oe_v, oexp);
    rd(A_DATA, v); chk(v == {16'h0, val}, "R6 read data", v, {16'h0, val});
    rd(A_STAT, v); chk(v[1] == 1'b0, "R7 no error", v, 0);
  endtask

  task automatic t_read_err();
    logic [31:0] v;
    arm(); phy_on = 1'b0;
    wr(A_CTL, 32'h8000 | (5'd5 << 5) | 5'd2);
    wait_idle();
    rd(A_STAT, v); chk(v[1] == 1'b1, "R7 error set", v, 2);
    t_read(0, 0, 16'h0F0F);  // clears the flag
  endtask

  task automatic t_pre_dis();
    arm();
    wr(A_CTL, 32'h0400 | (5'd1 << 5) | 5'd31);
    wr(A_DATA, 32'h0000_8001);
    wait_idle();
    chk(cap_v == frame(1, 2'b01, 5'd1, 5'd31, 2'b10, 16'h8001) && rcnt == 32, "R8 write no preamble",
        cap_v, frame(1, 2'b01, 5'd1, 5'd31, 2'b10, 16'h8001));
    wr(A_CTL, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v, d0;
    rd(A_DATA, d0);
    arm();
    wr(A_ADDR, 32'h0000_1111);
    wr(A_DATA, 32'h0000_2222);
    wr(A_ADDR, 32'h0000_3333);
    wr(A_CTL, 32'h8000);
    rd(A_DATA, v); chk(v == {16'h0, d0[15:0]}, "R9 data write ignored", v, {16'h0, d0[15:0]});
    rd(A_ADDR, v); chk(v == 32'h1111, "R9 address write ignored", v, 32'h1111);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(rcnt == 64, "R9 no extra frame", rcnt, 64);
  endtask

  task automatic t_min_half();
    int n;
    wr(A_STAT, 32'h0);
    arm();
    wr(A_DATA, 32'h0000_0042);
    @(posedge mdc); @(negedge clk); n = 0;
    while (mdc) begin n++; @(negedge clk); end
    chk(n == 1, "R3 half period div=0", n, 1);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_addr_frame();
    t_write_frame();
    t_read(0, 0, 16'hC35A);
    t_read(1, 0, 16'h7001);
    t_read(0, 1, 16'h9BDE);
    t_read_err();
    t_pre_dis();
    t_busy_ignore();
    t_min_half();
    chk(viol == 0, "R10 line held while MDC high", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule